// File: doc/BRIEF.md
# Manchester Frame Identifier Decoder

This block sits behind a frequency-shift demodulator that has already turned the tag's tones into a stream of half-bit symbols. Each accepted symbol is qualified by a strobe. The block looks for the frame boundary pattern 1,1,1,0,0,0, which can never occur in valid Manchester code. It then decodes the symbols that follow in pairs and shifts each recovered bit into a 64-bit accumulator made of an upper and a lower word.

A frame is closed by the next boundary pattern. If the accumulator holds a nonzero value at that point, its two words are copied to the outputs. A one-cycle strobe announces them, and a 16-bit card number is taken from the lower word. The accumulator is then cleared, and decoding of the next frame starts at once.

A pair that is not legal Manchester code abandons the frame. Decoding then resumes only after a fresh boundary.

Top module: `frame_id_decoder`

## Requirements
- R1: After reset, `id_hi`, `id_lo` and `card_num` are zero and `id_valid` is low.
- R2: A boundary is the six most recently accepted symbols reading 1,1,1,0,0,0, oldest first. After a boundary, the next accepted symbol is the first half of a pair.
- R3: The pair 0,1 yields bit 1 and the pair 1,0 yields bit 0. Bits enter the accumulator MSB first at bit 0 of the lower word, and bit 31 of the lower word moves into bit 0 of the upper word. Bits shifted past bit 63 are lost, so the last 64 bits decoded are kept.
- R4: The pair 0,0 or 1,1 clears the accumulator and returns the block to searching. Pairs received while searching change nothing.
- R5: At a boundary with a nonzero accumulator, `id_hi` and `id_lo` take the upper and lower words, the accumulator is cleared, and the following symbols start a new frame.
- R6: At a boundary with a zero accumulator, no strobe is produced and the outputs keep their previous values.
- R7: `id_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the last boundary symbol. The outputs stay unchanged until the next report.
- R8: Boundary search runs at every symbol position, including the middle of a pair. A boundary takes priority over pair decoding and restarts pair alignment.
- R9: A cycle with `sym_valid` low has no effect, whatever `sym_bit` holds.
- R10: `card_num` equals bits 16 down to 1 of the reported lower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Qualifies `sym_bit` for one cycle |
| sym_bit | input | 1 | Half-bit symbol from the demodulator |
| id_hi | output | 32 | Reported upper identifier word |
| id_lo | output | 32 | Reported lower identifier word |
| card_num | output | 16 | Card number field of the reported lower word |
| id_valid | output | 1 | One-cycle report strobe |

## Verification
A report appears one clock after the edge that accepts the sixth boundary symbol. The bench drives every symbol on a falling edge and reads the outputs on the next falling edge, so the strobe must show up exactly there. It must not show up after any of the five earlier boundary symbols. Pair decoding trails the input by the six-symbol window, but it is visible only through reports, so every data check waits for the closing boundary. The bench also checks one idle cycle after each report, where the strobe must already be low and the words unchanged.

// File: rtl/fid_pkg.sv
package fid_pkg;
   typedef enum logic {
      ST_SEARCH = 1'b0,
      ST_DECODE = 1'b1
   } fid_state_e;
endpackage

// File: rtl/fid_window.sv
// Sliding symbol window: the oldest symbol is the decode head, and the
// boundary test covers the whole window so it wins over pair decoding.
module fid_window #(
   parameter int                  MARK_LEN = 6,
   parameter logic [MARK_LEN-1:0] MARK_PAT = 6'b111000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sym_valid_i,
   input  logic sym_bit_i,
   output logic step_o,
   output logic head_o,
   output logic mark_o
);
   localparam int SKIP_W = (MARK_LEN > 2) ? $clog2(MARK_LEN) : 1;

   logic [MARK_LEN-1:0] win_q, win_d;
   logic [SKIP_W-1:0]   skip_q;

   assign win_d  = {win_q[MARK_LEN-2:0], sym_bit_i};
   assign step_o = sym_valid_i && (skip_q == '0);
   assign head_o = win_d[MARK_LEN-1];
   assign mark_o = step_o && (win_d == MARK_PAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         skip_q <= '0;
      end else if (sym_valid_i) begin
         win_q <= win_d;
         if (mark_o)
            skip_q <= SKIP_W'(MARK_LEN - 1);
         else if (skip_q != '0)
            skip_q <= skip_q - 1'b1;
      end
   end

   // A boundary consumes its whole window, so two cannot fire back to back.
   p_mark_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mark_o |=> !mark_o);
   // No decode step without an accepted symbol.
   p_idle_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid_i |-> !step_o && !mark_o);
endmodule

// File: rtl/fid_pair.sv
// Pair decoder: collects the head symbols two at a time while decoding.
module fid_pair
   import fid_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   input  logic head_i,
   input  logic mark_i,
   output logic shift_o,
   output logic shift_bit_o,
   output logic abort_o
);
   fid_state_e state_q;
   logic       phase_q;
   logic       first_q;
   logic       pair_done;

   assign pair_done   = step_i && !mark_i && (state_q == ST_DECODE) && phase_q;
   assign shift_o     = pair_done && (first_q != head_i);
   assign abort_o     = pair_done && (first_q == head_i);
   assign shift_bit_o = head_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SEARCH;
         phase_q <= 1'b0;
         first_q <= 1'b0;
      end else if (mark_i) begin
         state_q <= ST_DECODE;
         phase_q <= 1'b0;
      end else if (step_i && state_q == ST_DECODE) begin
         if (!phase_q) begin
            first_q <= head_i;
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            if (first_q == head_i)
               state_q <= ST_SEARCH;
         end
      end
   end

   p_abort_to_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> state_q == ST_SEARCH);
   p_mark_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mark_i |=> state_q == ST_DECODE && !phase_q);
   p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({shift_o, abort_o, mark_i}));
endmodule

// File: rtl/fid_accum.sv
// 64-bit identifier accumulator and report registers.
module fid_accum #(
   parameter int HI_W = 32,
   parameter int LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_i,
   input  logic            shift_bit_i,
   input  logic            abort_i,
   input  logic            mark_i,
   output logic [HI_W-1:0] id_hi_o,
   output logic [LO_W-1:0] id_lo_o,
   output logic            id_valid_o
);
   localparam int ACC_W = HI_W + LO_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] rep_q;
   logic             vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         rep_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (mark_i) begin
            if (acc_q != '0) begin
               rep_q <= acc_q;
               vld_q <= 1'b1;
            end
            acc_q <= '0;
         end else if (abort_i) begin
            acc_q <= '0;
         end else if (shift_i) begin
            acc_q <= {acc_q[ACC_W-2:0], shift_bit_i};
         end
      end
   end

   assign id_hi_o    = rep_q[ACC_W-1:LO_W];
   assign id_lo_o    = rep_q[LO_W-1:0];
   assign id_valid_o = vld_q;

   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid_o |=> !id_valid_o);
   p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid_o |-> $stable(id_hi_o) && $stable(id_lo_o));
   p_report_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid_o |-> (id_hi_o != '0) || (id_lo_o != '0));
endmodule

// File: rtl/frame_id_decoder.sv
module frame_id_decoder #(
   parameter int                  HI_W     = 32,
   parameter int                  LO_W     = 32,
   parameter int                  CARD_W   = 16,
   parameter int                  CARD_LSB = 1,
   parameter int                  MARK_LEN = 6,
   parameter logic [MARK_LEN-1:0] MARK_PAT = 6'b111000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sym_valid,
   input  logic              sym_bit,
   output logic [HI_W-1:0]   id_hi,
   output logic [LO_W-1:0]   id_lo,
   output logic [CARD_W-1:0] card_num,
   output logic              id_valid
);
   localparam int ACC_W = HI_W + LO_W;

   generate
      if (MARK_LEN < 2)
         $error("frame_id_decoder: MARK_LEN must be at least 2");
      if (MARK_PAT[MARK_LEN-1] != 1'b1)
         $error("frame_id_decoder: boundary must start with 1 to stay clear of the reset window");
      if (CARD_LSB + CARD_W > ACC_W)
         $error("frame_id_decoder: card field exceeds identifier width");
   endgenerate

   logic step, head, mark;
   logic shift, shift_bit, abort;

   fid_window #(.MARK_LEN(MARK_LEN), .MARK_PAT(MARK_PAT)) u_win (
      .clk(clk), .rst_n(rst_n), .sym_valid_i(sym_valid), .sym_bit_i(sym_bit),
      .step_o(step), .head_o(head), .mark_o(mark));

   fid_pair u_pair (
      .clk(clk), .rst_n(rst_n), .step_i(step), .head_i(head), .mark_i(mark),
      .shift_o(shift), .shift_bit_o(shift_bit), .abort_o(abort));

   fid_accum #(.HI_W(HI_W), .LO_W(LO_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .shift_i(shift), .shift_bit_i(shift_bit),
      .abort_i(abort), .mark_i(mark), .id_hi_o(id_hi), .id_lo_o(id_lo),
      .id_valid_o(id_valid));

   // The card field comes from the lower word alone when it fits there.
   generate
      if (CARD_LSB + CARD_W <= LO_W) begin : g_card_lo
         assign card_num = id_lo[CARD_LSB +: CARD_W];
      end else begin : g_card_wide
         logic [ACC_W-1:0] full_id;
         assign full_id  = {id_hi, id_lo};
         assign card_num = full_id[CARD_LSB +: CARD_W];
      end
   endgenerate

   p_card_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |=> $stable(card_num));
endmodule

// File: tb/sim_frame_id_decoder.sv
`timescale 1ns/1ps
module sim_frame_id_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sym_valid = 1'b0;
   logic        sym_bit = 1'b0;
   logic [31:0] id_hi, id_lo;
   logic [15:0] card_num;
   logic        id_valid;

   int n_chk = 0, n_bad = 0, pulses = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   frame_id_decoder u0 (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bit(sym_bit),
      .id_hi(id_hi), .id_lo(id_lo), .card_num(card_num), .id_valid(id_valid));

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_sym(input bit b, input int gap = 0);
      sym_valid = 1'b1;
      sym_bit   = b;
      @(negedge clk);
      sym_valid = 1'b0;
      if (id_valid) pulses++;
      for (int g = 0; g < gap; g++) begin
         sym_bit = ~sym_bit;
         @(negedge clk);
         if (id_valid) pulses++;
      end
   endtask

   task automatic send_bit(input bit b, input int gap = 0);
      send_sym(~b, gap);
      send_sym(b, gap);
   endtask

   task automatic send_bits(input logic [127:0] v, input int n, input int gap = 0);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i], gap);
   endtask

   task automatic send_marker(input int gap = 0);
      send_sym(1, gap); send_sym(1, gap); send_sym(1, gap);
      send_sym(0, gap); send_sym(0, gap); send_sym(0, gap);
   endtask

   // Closing boundary with strobe timing check, then report and hold checks.
   task automatic close_expect(input logic [63:0] exp, input string tag);
      logic [15:0] exp_card;
      exp_card = exp[16:1];
      check(pulses == 0, {tag, " R5 no early strobe"}, pulses, 0);
      for (int i = 0; i < 5; i++) send_sym(i < 3);
      check(!id_valid, {tag, " R7 strobe not before last symbol"}, id_valid, 0);
      send_sym(0);
      check(id_valid === 1'b1, {tag, " R7 strobe after last symbol"}, id_valid, 1);
      check({id_hi, id_lo} === exp, {tag, " R3 R5 identifier"}, {id_hi, id_lo}, exp);
      check(card_num === exp_card, {tag, " R10 card number"}, card_num, exp_card);
      @(negedge clk);
      check(!id_valid, {tag, " R7 single cycle"}, id_valid, 0);
      check({id_hi, id_lo} === exp, {tag, " R7 hold"}, {id_hi, id_lo}, exp);
      pulses = 0;
   endtask

   task automatic t_reset;
      check(id_hi == 0 && id_lo == 0 && card_num == 0 && !id_valid, "R1 reset state",
            {id_hi, id_lo}, 0);
   endtask

   task automatic t_basic;
      pulses = 0;
      send_marker();
      check(pulses == 0, "R6 empty leading boundary", pulses, 0);
      send_bits({12'h2C7, 32'hDEADBEEF}, 44);
      close_expect(64'h0000_02C7_DEAD_BEEF, "basic R2");
   endtask

   task automatic t_back_to_back;
      send_bits(44'h001_0000_0003, 44);
      close_expect(64'h0000_0001_0000_0003, "chained R5");
   endtask

   task automatic t_zero_id;
      pulses = 0;
      send_bits(0, 20);
      send_marker();
      check(pulses == 0, "R6 zero frame no strobe", pulses, 0);
      check({id_hi, id_lo} === 64'h0000_0001_0000_0003, "R6 outputs kept",
            {id_hi, id_lo}, 64'h0000_0001_0000_0003);
   endtask

   task automatic t_abort;
      pulses = 0;
      send_bits(8'hA5, 8);
      send_sym(1); send_sym(1);
      send_bits(4'b0110, 4);
      send_marker();
      check(pulses == 0, "R4 pair 1,1 aborted frame", pulses, 0);
      send_bits(4'hA, 4);
      close_expect(64'h0000_0000_0000_000A, "after abort R4");
      send_bits(2'b11, 2);
      send_sym(0); send_sym(0);
      send_marker();
      check(pulses == 0, "R4 pair 0,0 aborted frame", pulses, 0);
   endtask

   task automatic t_realign;
      pulses = 0;
      send_bits(3'b101, 3);
      send_sym(0);
      close_expect(64'h5, "mid-pair boundary R8");
      send_bits(2'b11, 2);
      close_expect(64'h3, "realigned R8");
   endtask

   task automatic t_overflow;
      send_bits({6'h3F, 64'h8123_4567_89AB_CDEF}, 70);
      close_expect(64'h8123_4567_89AB_CDEF, "overflow R3");
   endtask

   task automatic t_gaps;
      send_bits(16'hBEEF, 16, 2);
      close_expect(64'h0000_BEEF, "gapped R9");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_back_to_back();
      t_zero_id();
      t_abort();
      t_realign();
      t_overflow();
      t_gaps();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      end
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      end
      $finish;
   end
endmodule